// File: doc/BRIEF.md
# Corner-Turn Write Address Interleaver

This block sits on the write side of a corner-turn memory. A frame of complex samples arrives one row at a time: row 0 from column 0 up to the last column, then row 1, and so on. Each sample is a 32-bit real half and a 32-bit imaginary half, and the two halves are stored in separate 32-bit devices. For every accepted sample the block returns the memory group, bank, row and column to write. It also passes both data halves through, one cycle late.

The placement interleaves the data so that a later column-ordered read can rotate through the banks without stalling. The group toggles every four columns. The bank comes from the four-row block index. Within a bank, the four-row blocks that share a bank row are packed together. The block marks the first word of every four-word burst and pulses once when the last sample of a frame leaves. After that pulse its counters wrap to the start of a new frame.

Top module: `ct_wr_interleave`

## Requirements
- R1: After reset, out_valid, burst_start and frame_done are low, and the first accepted sample is treated as row 0, column 0.
- R2: Each sample accepted with in_valid high appears exactly one cycle later with out_valid high. Its real and imaginary halves are unchanged.
- R3: out_grp is 0 when the column's four-column block index (y/4) is even, and 1 when it is odd. The group therefore toggles after every four consecutive samples of a row.
- R4: out_bank equals (x/4) mod 4, where x is the frame row. The four rows of a block share one bank, and successive blocks rotate through banks 0 to 3.
- R5: The in-bank address is the concatenation {x/16, x mod 4, y/8, y mod 4}, most significant field first. Its low MCOL_W bits form out_col and the remaining high bits form out_row.
- R6: Over one frame, each combination of group, bank, row and column is written exactly once. The mapping is a bijection onto the two groups' banks.
- R7: burst_start is high on an output sample exactly when its column satisfies y mod 4 = 0.
- R8: frame_done is high on the output of the sample at the last row and last column, and on no other sample. The next accepted sample is row 0, column 0.
- R9: While in_valid is low, out_valid is low on the following cycle and the row and column counters do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_re | input | HALF_W | Real half of the sample |
| in_im | input | HALF_W | Imaginary half of the sample |
| out_valid | output | 1 | Placement for one sample is valid |
| out_re | output | HALF_W | Real half, delayed one cycle |
| out_im | output | HALF_W | Imaginary half, delayed one cycle |
| out_grp | output | 1 | Target group: 0 = first, 1 = second |
| out_bank | output | 2 | Target bank 0..3 |
| out_row | output | ROW_BITS+COL_BITS-3-MCOL_W | Memory row inside the bank |
| out_col | output | MCOL_W | Memory column inside the bank |
| burst_start | output | 1 | First word of a four-word burst |
| frame_done | output | 1 | Last sample of the frame |

## Verification
The bench runs a scaled 32 x 32 frame with random gaps in in_valid. It covers three frame wraps, so a counter that skips the idle cycles, or advances during them, shows up as wrong coordinates in every later sample. A bitmap of used addresses for each group and bank catches a field-order or field-width mistake: such a mistake writes one address twice and leaves holes, which breaks the bijection at the end of each frame. Directed checks look at the group toggle on the y mod 8 = 4 boundary, at the bank change every four rows, and at frame_done on the very last sample. An off-by-one there either fires early or fails to restart at row 0.

// File: rtl/ct_wr_interleave.sv
module ct_wr_interleave #(
  parameter int ROW_BITS = 12,
  parameter int COL_BITS = 12,
  parameter int HALF_W   = 32,
  parameter int MCOL_W   = 9,
  localparam int ADDR_W  = ROW_BITS + COL_BITS - 3,
  localparam int MROW_W  = ADDR_W - MCOL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_re,
  input  logic [HALF_W-1:0] in_im,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_re,
  output logic [HALF_W-1:0] out_im,
  output logic              out_grp,
  output logic [1:0]        out_bank,
  output logic [MROW_W-1:0] out_row,
  output logic [MCOL_W-1:0] out_col,
  output logic              burst_start,
  output logic              frame_done
);

  logic [ROW_BITS-1:0] x;
  logic [COL_BITS-1:0] y;
  logic [ADDR_W-1:0]   addr;

  wire last_col = &y;
  wire last_row = &x;

  assign addr = {x[ROW_BITS-1:4], x[1:0], y[COL_BITS-1:3], y[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (in_valid) begin
      y <= y + 1'b1;
      if (last_col) x <= x + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_re      <= '0;
      out_im      <= '0;
      out_grp     <= 1'b0;
      out_bank    <= '0;
      out_row     <= '0;
      out_col     <= '0;
      burst_start <= 1'b0;
      frame_done  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      burst_start <= in_valid && (y[1:0] == 2'd0);
      frame_done  <= in_valid && last_col && last_row;
      if (in_valid) begin
        out_re   <= in_re;
        out_im   <= in_im;
        out_grp  <= y[2];
        out_bank <= x[3:2];
        out_row  <= addr[ADDR_W-1:MCOL_W];
        out_col  <= addr[MCOL_W-1:0];
      end
    end
  end

  logic       seen_q;
  logic       grp_q;
  logic [1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      grp_q  <= 1'b0;
      bank_q <= '0;
    end else if (out_valid) begin
      seen_q <= 1'b1;
      grp_q  <= out_grp;
      bank_q <= out_bank;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !burst_start && !frame_done);

  assert_burst_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !burst_start && seen_q) |-> (out_grp == grp_q) && (out_bank == bank_q));

  assert_burst_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> out_valid);

  assert_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> out_valid && out_grp && (out_bank == 2'd3) && !burst_start);

endmodule

// File: tb/ct_wr_interleave_tb.sv
module ct_wr_interleave_tb;
  localparam int RB = 5;
  localparam int CB = 5;
  localparam int HW = 32;
  localparam int MC = 3;
  localparam int AW = RB + CB - 3;
  localparam int MR = AW - MC;
  localparam int NX = 1 << RB;
  localparam int NY = 1 << CB;
  localparam int SLOTS = 8 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [HW-1:0] in_re = '0, in_im = '0;
  logic out_valid, out_grp, burst_start, frame_done;
  logic [HW-1:0] out_re, out_im;
  logic [1:0] out_bank;
  logic [MR-1:0] out_row;
  logic [MC-1:0] out_col;

  always #2.5 clk = ~clk;

  ct_wr_interleave #(.ROW_BITS(RB), .COL_BITS(CB), .HALF_W(HW), .MCOL_W(MC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_grp(out_grp),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .burst_start(burst_start), .frame_done(frame_done));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit used [SLOTS];

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int x, input int y);
    return ((((x / 16) * 4 + (x % 4)) * (NY / 8) + (y / 8)) * 4) + (y % 4);
  endfunction

  int ex = 0, ey = 0;
  bit pv = 1'b0;
  int px = 0, py = 0;
  logic [HW-1:0] pre = '0, pim = '0;

  task automatic check_out();
    int a, slot;
    check("R2 out_valid", out_valid, pv);
    if (!pv) begin
      check("R9 burst_start idle", burst_start, 0);
      check("R9 frame_done idle", frame_done, 0);
      return;
    end
    a = exp_addr(px, py);
    check("R2 real half", out_re, pre);
    check("R2 imag half", out_im, pim);
    check("R3 group", out_grp, (py / 4) % 2);
    check("R4 bank", out_bank, (px / 4) % 4);
    check("R5 row", out_row, a >> MC);
    check("R5 col", out_col, a % (1 << MC));
    check("R7 burst_start", burst_start, (py % 4) == 0);
    check("R8 frame_done", frame_done, (px == NX - 1) && (py == NY - 1));
    slot = (((out_grp * 4) + out_bank) << AW) + (out_row << MC) + out_col;
    check("R6 slot unused", used[slot], 0);
    used[slot] = 1'b1;
    if (px == NX - 1 && py == NY - 1) begin
      int cnt = 0;
      foreach (used[i]) cnt += used[i];
      check("R6 all slots filled", cnt, SLOTS);
      foreach (used[i]) used[i] = 1'b0;
    end
  endtask

  task automatic step(input bit v);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_re = $urandom;
    in_im = $urandom;
    pv = v;
    pre = in_re;
    pim = in_im;
    px = ex;
    py = ey;
    if (v) begin
      if (ey == NY - 1) begin
        ey = 0;
        ex = (ex + 1) % NX;
      end else ey++;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", out_valid, 0);
    check("R1 burst_start reset", burst_start, 0);
    check("R1 frame_done reset", frame_done, 0);
    rst_n = 1'b1;
    // directed: first samples from (0,0), then an idle stretch
    for (int i = 0; i < 10; i++) step(1'b1);
    for (int i = 0; i < 4; i++) step(1'b0);
    // R9 at the port: the next sample must continue at column 10
    for (int i = 0; i < 3; i++) step(1'b1);
    for (int i = 0; i < 3 * NX * NY + 200; i++) step(($urandom % 10) < 7);
    // complete the frame in progress with gapless input
    while (!(ex == 0 && ey == 0)) step(1'b1);
    step(1'b0);
    step(1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule